// File: doc/BRIEF.md
# DMA Channel Event Dispatcher

This block sits in front of a DMA transfer engine. It records trigger requests for a bank of DMA channels (64 by default) in a pending-event vector and hands the engine one channel at a time. A request can come from three places. A peripheral can raise its hardware event line. Software can write a one into the set register. A finished transfer that has chaining turned on can name another channel through its completion code.

Software controls the block through a single write port that selects one of three registers. The enable register is loaded whole and decides which pending channels may be dispatched. The clear register removes pending bits where the written data has a one. The set register posts pending bits where the written data has a one. The pending and enable vectors are brought out as plain outputs so that the surrounding logic can read them.

While the engine reports that it is ready, the block raises a grant for the lowest-numbered channel that is both pending and enabled. The granted channel's pending bit is cleared at the same clock edge.

Top module: `dma_event_dispatch`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pend_o` and `en_o` are all zeros and `grant_vld_o` is low.
- R2: When `hw_evt_i[n]` is high at a clock edge, `pend_o[n]` is one after that edge.
- R3: A write with `wr_sel_i` = 0 loads `wr_data_i` into `en_o` at the next edge. A pending channel whose enable bit is zero is never granted.
- R4: A write with `wr_sel_i` = 1 clears every pending bit where `wr_data_i` is one. Bits where the data is zero are unchanged.
- R5: A write with `wr_sel_i` = 2 sets every pending bit where `wr_data_i` is one. Bits where the data is zero are unchanged.
- R6: When `chain_vld_i` is high, the pending bit whose index equals `chain_code_i` is one after the edge.
- R7: When more than one channel is pending and enabled, `grant_ch_o` is the lowest such channel number.
- R8: `grant_vld_o` is high only while `eng_ready_i` is high. While it is low, pending bits are kept.
- R9: A granted channel's pending bit is zero after the edge, unless a set source names that channel in the same cycle.
- R10: If any set source (hardware event, set write, chain trigger) and any clear source (clear write or grant) hit the same bit in one cycle, the bit ends up one.
- R11: A write with `wr_sel_i` = 3 changes neither `pend_o` nor `en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| hw_evt_i | input | NCH | Hardware event lines, one per channel, sampled at each edge |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 enable, 1 clear, 2 set, 3 no register |
| wr_data_i | input | NCH | Write data, one bit per channel |
| chain_vld_i | input | 1 | A completed transfer with chaining on requests a channel |
| chain_code_i | input | CHW | Completion code, which is the channel to trigger |
| eng_ready_i | input | 1 | The transfer engine can accept a channel |
| pend_o | output | NCH | Pending-event vector |
| en_o | output | NCH | Enable mask |
| grant_vld_o | output | 1 | A channel is granted this cycle |
| grant_ch_o | output | CHW | Granted channel number; zero when no grant |

## Verification
The assertions are disabled while the internal synchronized reset is low. They assume the inputs are known and stable at every clock edge. For the properties about set sources, clear writes and the unused register select, they also assume the stimulus produces one of the specific input combinations each property is conditioned on, for example a clear write with no set source on the same bit.

The bench drives every input on the falling edge. It keeps the event, write and chain inputs low until the synchronizer has released, so no stimulus falls into the reset window. After the directed phases, it produces random conflicts between set and clear sources. The hardware event words are sparse, so grants keep draining the pending vector and the lowest-number rule gets exercised against changing vectors.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_CLEAR  = 2'd1,
    SEL_SET    = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/dma_evt_post.sv
module dma_evt_post
  import dma_evt_pkg::*;
#(
  parameter int NCH = 64,
  parameter int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] hw_evt_i,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_sel_i,
  input  logic [NCH-1:0] wr_data_i,
  input  logic           chain_vld_i,
  input  logic [CHW-1:0] chain_code_i,
  input  logic           grant_vld_i,
  input  logic [CHW-1:0] grant_ch_i,
  output logic [NCH-1:0] set_vec_o,
  output logic [NCH-1:0] clr_vec_o,
  output logic           en_load_o
);

  logic [NCH-1:0] chain_hot;
  logic [NCH-1:0] grant_hot;
  logic           wr_clear;
  logic           wr_set;

  // One-hot decode of the chain code and the granted channel.
  for (genvar k = 0; k < NCH; k++) begin : g_decode
    assign chain_hot[k] = chain_vld_i && (chain_code_i == CHW'(k));
    assign grant_hot[k] = grant_vld_i && (grant_ch_i == CHW'(k));
  end

  always_comb begin
    wr_clear  = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_CLEAR);
    wr_set    = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_SET);
    en_load_o = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_ENABLE);
    set_vec_o = hw_evt_i | chain_hot | (wr_set ? wr_data_i : '0);
    clr_vec_o = grant_hot | (wr_clear ? wr_data_i : '0);
  end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 64,
  parameter int GRP = 8,
  parameter int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req_i,
  output logic           vld_o,
  output logic [CHW-1:0] idx_o
);

  localparam int NGRP = NCH / GRP;
  localparam int GW   = (GRP > 1) ? $clog2(GRP) : 1;

  logic [NGRP-1:0] grp_any;
  logic [GW-1:0]   grp_idx [NGRP];

  // First level: lowest request inside each group.
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GRP-1:0] slice;
    assign slice      = req_i[g*GRP +: GRP];
    assign grp_any[g] = |slice;
    always_comb begin
      grp_idx[g] = '0;
      for (int i = GRP - 1; i >= 0; i--) begin
        if (slice[i]) grp_idx[g] = GW'(i);
      end
    end
  end

  // Second level: lowest group that has a request.
  always_comb begin
    int sel;
    sel = 0;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (grp_any[g]) sel = g;
    end
    vld_o = |grp_any;
    idx_o = CHW'(sel * GRP + int'(grp_idx[sel]));
  end

endmodule

// File: rtl/dma_event_dispatch.sv
module dma_event_dispatch #(
  parameter int NCH = 64,
  parameter int GRP = 8,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hw_evt_i,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_sel_i,
  input  logic [NCH-1:0] wr_data_i,
  input  logic           chain_vld_i,
  input  logic [CHW-1:0] chain_code_i,
  input  logic           eng_ready_i,
  output logic [NCH-1:0] pend_o,
  output logic [NCH-1:0] en_o,
  output logic           grant_vld_o,
  output logic [CHW-1:0] grant_ch_o
);

  logic           rst_sync_n;
  logic [NCH-1:0] pend_q, pend_d;
  logic [NCH-1:0] en_q, en_d;
  logic [NCH-1:0] set_vec, clr_vec;
  logic           en_load;
  logic           pick_vld;
  logic [CHW-1:0] pick_idx;

  dma_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  dma_prio_pick #(.NCH(NCH), .GRP(GRP), .CHW(CHW)) u_pick (
    .req_i (pend_q & en_q),
    .vld_o (pick_vld),
    .idx_o (pick_idx)
  );

  always_comb begin
    grant_vld_o = eng_ready_i && pick_vld;
    grant_ch_o  = grant_vld_o ? pick_idx : '0;
  end

  dma_evt_post #(.NCH(NCH), .CHW(CHW)) u_post (
    .hw_evt_i     (hw_evt_i),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .wr_data_i    (wr_data_i),
    .chain_vld_i  (chain_vld_i),
    .chain_code_i (chain_code_i),
    .grant_vld_i  (grant_vld_o),
    .grant_ch_i   (grant_ch_o),
    .set_vec_o    (set_vec),
    .clr_vec_o    (clr_vec),
    .en_load_o    (en_load)
  );

  // Next state: clears first, then sets, so a set wins on a shared bit.
  always_comb begin
    pend_d = (pend_q & ~clr_vec) | set_vec;
    en_d   = en_load ? wr_data_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      if (en_load) en_q <= en_d;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

endmodule

// File: rtl/dma_event_dispatch_chk.sv
module dma_event_dispatch_chk #(
  parameter int NCH = 64,
  parameter int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] hw_evt_i,
  input logic           wr_en_i,
  input logic [1:0]     wr_sel_i,
  input logic [NCH-1:0] wr_data_i,
  input logic           chain_vld_i,
  input logic [CHW-1:0] chain_code_i,
  input logic           eng_ready_i,
  input logic [NCH-1:0] pend_o,
  input logic [NCH-1:0] en_o,
  input logic           grant_vld_o,
  input logic [CHW-1:0] grant_ch_o
);

  localparam logic [NCH-1:0] ONE = NCH'(1);

  // R2
  hw_evt_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_evt_i) |=> ((pend_o & $past(hw_evt_i)) == $past(hw_evt_i)));

  // R3
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd0) |=> (en_o == $past(wr_data_i)));

  // R3
  grant_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o |-> (pend_o[grant_ch_o] && en_o[grant_ch_o]));

  // R4
  clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd1 && (hw_evt_i & wr_data_i) == '0 && !chain_vld_i)
    |=> ((pend_o & $past(wr_data_i)) == '0));

  // R5
  set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd2) |=> ((pend_o & $past(wr_data_i)) == $past(wr_data_i)));

  // R6
  chain_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_vld_i |=> pend_o[$past(chain_code_i)]);

  // R7
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o |-> ((pend_o & en_o & ((ONE << grant_ch_o) - ONE)) == '0));

  // R8
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_ready_i |-> !grant_vld_o);

  // R9
  grant_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && !hw_evt_i[grant_ch_o] && !(chain_vld_i && chain_code_i == grant_ch_o)
     && !(wr_en_i && wr_sel_i == 2'd2 && wr_data_i[grant_ch_o]))
    |=> !pend_o[$past(grant_ch_o)]);

  // R10
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd1 && (|(wr_data_i & hw_evt_i)))
    |=> ((pend_o & $past(wr_data_i & hw_evt_i)) == $past(wr_data_i & hw_evt_i)));

  // R11
  unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd3 && hw_evt_i == '0 && !chain_vld_i && !grant_vld_o)
    |=> (pend_o == $past(pend_o) && en_o == $past(en_o)));

endmodule

bind dma_event_dispatch dma_event_dispatch_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .hw_evt_i     (hw_evt_i),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .wr_data_i    (wr_data_i),
  .chain_vld_i  (chain_vld_i),
  .chain_code_i (chain_code_i),
  .eng_ready_i  (eng_ready_i),
  .pend_o       (pend_o),
  .en_o         (en_o),
  .grant_vld_o  (grant_vld_o),
  .grant_ch_o   (grant_ch_o)
);

// File: tb/dma_event_dispatch_bench.sv
module dma_event_dispatch_bench;

  localparam int NCH = 64;
  localparam int CHW = 6;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] hw_evt;
  logic           wr_en;
  logic [1:0]     wr_sel;
  logic [NCH-1:0] wr_data;
  logic           chain_vld;
  logic [CHW-1:0] chain_code;
  logic           ready;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] en;
  logic           gvld;
  logic [CHW-1:0] gch;

  int compared;
  int mismatched;
  bit done;

  // Reference state
  logic [NCH-1:0] m_pend;
  logic [NCH-1:0] m_en;

  dma_event_dispatch u_dma_event_dispatch (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_evt_i     (hw_evt),
    .wr_en_i      (wr_en),
    .wr_sel_i     (wr_sel),
    .wr_data_i    (wr_data),
    .chain_vld_i  (chain_vld),
    .chain_code_i (chain_code),
    .eng_ready_i  (ready),
    .pend_o       (pend),
    .en_o         (en),
    .grant_vld_o  (gvld),
    .grant_ch_o   (gch)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // Compares outputs with the model; inputs are already applied.
  task automatic compare(input string tag, output bit egv, output int egc);
    egv = 1'b0;
    egc = 0;
    if (ready) begin
      for (int i = NCH - 1; i >= 0; i--) begin
        if (m_pend[i] && m_en[i]) begin
          egv = 1'b1;
          egc = i;
        end
      end
    end
    compared++;
    if (pend !== m_pend || en !== m_en || gvld !== egv || (egv && gch !== CHW'(egc))) begin
      mismatched++;
      $display("FAIL %s: pend=%h en=%h gvld=%0b gch=%0d expected pend=%h en=%h gvld=%0b gch=%0d",
               tag, pend, en, gvld, gch, m_pend, m_en, egv, egc);
    end
  endtask

  // One cycle: drive on the falling edge, check, advance the model at the rising edge.
  task automatic step(input logic [NCH-1:0] h, input logic we, input logic [1:0] sel,
                      input logic [NCH-1:0] d, input logic cv, input logic [CHW-1:0] cc,
                      input logic rdy, input string tag);
    bit egv;
    int egc;
    logic [NCH-1:0] s, c;
    hw_evt = h; wr_en = we; wr_sel = sel; wr_data = d;
    chain_vld = cv; chain_code = cc; ready = rdy;
    #1;
    compare(tag, egv, egc);
    s = h;
    c = '0;
    if (we && sel == 2'd2) s = s | d;
    if (we && sel == 2'd1) c = c | d;
    if (cv) s[cc] = 1'b1;
    if (egv) c[egc] = 1'b1;
    @(posedge clk);
    m_pend = (m_pend & ~c) | s;
    if (we && sel == 2'd0) m_en = d;
    @(negedge clk);
  endtask

  task automatic idle(input logic rdy, input int n, input string tag);
    for (int i = 0; i < n; i++) step('0, 1'b0, 2'd0, '0, 1'b0, '0, rdy, tag);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [NCH-1:0] allones;
    compared = 0; mismatched = 0; done = 1'b0;
    allones = '1;
    rst_n = 1'b0;
    hw_evt = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    chain_vld = 1'b0; chain_code = '0; ready = 1'b0;
    m_pend = '0; m_en = '0;
    @(negedge clk);
    // R1: reset state, held and just after release
    idle(1'b1, 3, "R1");
    rst_n = 1'b1;
    idle(1'b1, 4, "R1");

    // R3: enable every channel
    step('0, 1'b1, 2'd0, allones, 1'b0, '0, 1'b0, "R3");
    // R2: hardware events on 5 and 40, engine busy
    step(NCH'(1) << 40 | NCH'(1) << 5, 1'b0, 2'd0, '0, 1'b0, '0, 1'b0, "R2");
    // R8: held while not ready
    idle(1'b0, 3, "R8");
    // R7, R9: two grants, lowest first
    idle(1'b1, 3, "R7");

    // R3: mask off channel 3, post it by software (R5), no grant
    step('0, 1'b1, 2'd0, ~(NCH'(1) << 3), 1'b0, '0, 1'b0, "R3");
    step('0, 1'b1, 2'd2, NCH'(1) << 3, 1'b0, '0, 1'b1, "R5");
    idle(1'b1, 2, "R3");
    step('0, 1'b1, 2'd0, allones, 1'b0, '0, 1'b1, "R3");
    idle(1'b1, 2, "R9");

    // R4: post 0..3, clear 0 and 2, zero-data clear is harmless
    step('0, 1'b1, 2'd2, NCH'(64'hF), 1'b0, '0, 1'b0, "R5");
    step('0, 1'b1, 2'd1, NCH'(64'h5), 1'b0, '0, 1'b0, "R4");
    step('0, 1'b1, 2'd1, '0, 1'b0, '0, 1'b0, "R4");
    idle(1'b0, 1, "R4");

    // R10: clear write and hardware event on channel 1 together
    step(NCH'(1) << 1, 1'b1, 2'd1, NCH'(64'h2), 1'b0, '0, 1'b0, "R10");
    // R10: grant of channel 1 with a fresh event on it
    step(NCH'(1) << 1, 1'b0, 2'd0, '0, 1'b0, '0, 1'b1, "R10");
    idle(1'b0, 1, "R10");

    // R11: unused select with all ones
    step('0, 1'b1, 2'd3, allones, 1'b0, '0, 1'b0, "R11");
    idle(1'b0, 1, "R11");

    // R6: chain triggers for 63 and 0
    step('0, 1'b0, 2'd0, '0, 1'b1, 6'd63, 1'b0, "R6");
    step('0, 1'b0, 2'd0, '0, 1'b1, 6'd0, 1'b0, "R6");
    idle(1'b1, 6, "R7");

    // Random mix of all sources
    for (int i = 0; i < 4000; i++) begin
      logic [NCH-1:0] h, d;
      logic [1:0] sel;
      h = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      d = {$urandom, $urandom};
      sel = 2'($urandom);
      step(h, 1'($urandom % 3 == 0), sel, d, 1'($urandom % 4 == 0), CHW'($urandom),
           1'($urandom % 4 != 0), "R7 mix");
    end
    idle(1'b1, 70, "R9 drain");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule